// File: doc/BRIEF.md
# Character Display Write Sequencer

This block sits on the host side of a character display that takes an 8-bit parallel write bus with an active-low select, an active-low write strobe and one register-select line. Register-select low marks a command byte and high marks a data byte. After reset the block sends the display's power-up command list on its own. It then accepts host requests one at a time over a valid/ready handshake.

A request either writes one character at a row and column, or loads an eight-byte pixel pattern into one of the eight user glyph slots. A character request becomes a position command followed by the character byte. A glyph request becomes a glyph-slot address command, then eight pattern bytes, then a position command that puts the cursor back at the row and column given with the request. Each bus write presents its byte for a fixed setup time, strobes for a fixed time, and then leaves the bus quiet for a fixed recovery time. The recovery after the clear command is longer. The block never reads the display's busy flag.

Top module: `chardisp_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after release, `disp_cs_n` and `disp_wr_n` are 1 and `req_ready` is 0.
- R2: After reset, the first four bus writes are commands (`disp_rs` = 0) carrying 0x38, 0x0C, 0x01 and 0x06, in that order. No other write comes before them.
- R3: `req_ready` stays 0 until the fourth power-up write has ended. A request held valid during power-up is taken afterwards, unchanged.
- R4: A character request (`req_glyph` = 0) produces a command whose bit 7 is 1, bit 6 is `req_row` and bits 5:0 are `req_col`, so row 1 column 2 gives 0xC2. It is followed by a data write (`disp_rs` = 1) of `req_char`.
- R5: A glyph request (`req_glyph` = 1) produces the command 0x40 with `req_code` in bits 5:3. It is followed by eight data writes. Write i carries `req_bitmap[5i+4:5i]` in bits 4:0, with bits 7:5 zero.
- R6: After the eighth pattern byte of a glyph request, the block issues a position command for `req_row`/`req_col`, encoded as in R4.
- R7: `disp_wr_n` is low only while `disp_cs_n` is low. `disp_rs` and `disp_d` do not change while `disp_cs_n` stays low.
- R8: Before each strobe, `disp_cs_n` is low with `disp_wr_n` high for exactly SETUP_CYC cycles. `disp_wr_n` then stays low for exactly STROBE_CYC cycles and rises in the same cycle as `disp_cs_n`.
- R9: Between two writes, `disp_cs_n` stays high for at least GAP_CYC cycles, or for at least CLR_GAP_CYC cycles after the command 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_glyph | input | 1 | 0: character write, 1: glyph load |
| req_row | input | 1 | Display row (also the restore row for a glyph load) |
| req_col | input | COL_W | Display column (also the restore column for a glyph load) |
| req_char | input | 8 | Character code for a character write |
| req_code | input | 3 | Glyph slot 0 to 7 |
| req_bitmap | input | 40 | Eight 5-bit pattern rows, row 0 in the low bits |
| disp_cs_n | output | 1 | Display select, active low |
| disp_wr_n | output | 1 | Display write strobe, active low |
| disp_rs | output | 1 | Register select: 0 command, 1 data |
| disp_d | output | 8 | Display data bus |

## Verification
The assertions assume that request fields stay stable while `req_valid` is high and `req_ready` is low. They also assume that columns fit the 6-bit position field. The bench changes its request fields only on falling clock edges. It keeps every field fixed from the moment it raises `req_valid` until the cycle after the request is taken, including while it waits through power-up. The recovery checks assume that the only long-recovery command is the clear byte. The bench therefore never sends a character or glyph request whose generated command equals 0x01.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

  typedef enum logic [2:0] {
    PH_PWR,
    PH_PWR_DRAIN,
    PH_READY,
    PH_POS,
    PH_CHAR,
    PH_GCMD,
    PH_GROW,
    PH_GPOS
  } phase_t;

  localparam int unsigned PWR_LEN     = 4;
  localparam int unsigned GLYPH_BYTES = 8;
  localparam int unsigned PIX_W       = 5;
  localparam int unsigned BITMAP_W    = GLYPH_BYTES * PIX_W;

  localparam logic [7:0] CMD_CLEAR = 8'h01;
  localparam logic [7:0] CMD_POS   = 8'h80;
  localparam logic [7:0] CMD_GLYPH = 8'h40;
  localparam logic [7:0] ROW1_BASE = 8'h40;

  // Power-up command list, in issue order
  function automatic logic [7:0] pwr_cmd(input logic [1:0] step);
    logic [7:0] b;
    unique case (step)
      2'd0:    b = 8'h38;
      2'd1:    b = 8'h0C;
      2'd2:    b = CMD_CLEAR;
      default: b = 8'h06;
    endcase
    return b;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/chardisp_bus_wr.sv
module chardisp_bus_wr
  import chardisp_pkg::*;
#(
  parameter int unsigned SETUP_CYC   = 2,
  parameter int unsigned STROBE_CYC  = 3,
  parameter int unsigned GAP_CYC     = 8,
  parameter int unsigned CLR_GAP_CYC = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] go_byte,
  input  logic       go_rs,
  output logic       idle,
  output logic       cs_n,
  output logic       wr_n,
  output logic       rs,
  output logic [7:0] d
);

  localparam int unsigned LONGEST = max2(max2(SETUP_CYC, STROBE_CYC), max2(GAP_CYC, CLR_GAP_CYC));
  localparam int unsigned CW      = $clog2(LONGEST + 1);

  typedef enum logic [1:0] {W_IDLE, W_SETUP, W_STROBE, W_GAP} wst_t;

  wst_t          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    byte_q;
  logic          rs_q;
  logic          long_q;
  logic          cnt_zero;
  logic          accept;

  assign cnt_zero = (cnt_q == '0);
  assign accept   = go && (st_q == W_IDLE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      W_IDLE: begin
        if (go) begin
          st_d  = W_SETUP;
          cnt_d = CW'(SETUP_CYC - 1);
        end
      end
      W_SETUP: begin
        if (cnt_zero) begin
          st_d  = W_STROBE;
          cnt_d = CW'(STROBE_CYC - 1);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      W_STROBE: begin
        if (cnt_zero) begin
          st_d  = W_GAP;
          cnt_d = long_q ? CW'(CLR_GAP_CYC - 1) : CW'(GAP_CYC - 1);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      W_GAP: begin
        if (cnt_zero) st_d = W_IDLE;
        else          cnt_d = cnt_q - CW'(1);
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= W_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // Byte, select and recovery length are captured once per write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      rs_q   <= 1'b0;
      long_q <= 1'b0;
    end else if (accept) begin
      byte_q <= go_byte;
      rs_q   <= go_rs;
      long_q <= !go_rs && (go_byte == CMD_CLEAR);
    end
  end

  assign idle = (st_q == W_IDLE);
  assign cs_n = !((st_q == W_SETUP) || (st_q == W_STROBE));
  assign wr_n = (st_q != W_STROBE);
  assign rs   = rs_q;
  assign d    = byte_q;

endmodule

// File: rtl/chardisp_byte_src.sv
module chardisp_byte_src
  import chardisp_pkg::*;
#(
  parameter int unsigned COL_W = 6
) (
  input  phase_t              phase,
  input  logic [2:0]          idx,
  input  logic                row,
  input  logic [COL_W-1:0]    col,
  input  logic [7:0]          chr,
  input  logic [2:0]          code,
  input  logic [BITMAP_W-1:0] bitmap,
  output logic [7:0]          wbyte,
  output logic                wrs
);

  logic [7:0] row_bytes [GLYPH_BYTES];
  logic [7:0] pos_cmd;
  logic [7:0] glyph_cmd;

  for (genvar g = 0; g < GLYPH_BYTES; g++) begin : g_rows
    assign row_bytes[g] = {{(8 - PIX_W){1'b0}}, bitmap[g*PIX_W +: PIX_W]};
  end

  assign pos_cmd   = CMD_POS | (row ? ROW1_BASE : 8'h00) | 8'(col);
  assign glyph_cmd = CMD_GLYPH | {2'b00, code, 3'b000};

  always_comb begin
    wbyte = 8'h00;
    wrs   = 1'b0;
    unique case (phase)
      PH_PWR:          wbyte = pwr_cmd(idx[1:0]);
      PH_POS, PH_GPOS: wbyte = pos_cmd;
      PH_CHAR: begin
        wbyte = chr;
        wrs   = 1'b1;
      end
      PH_GCMD:         wbyte = glyph_cmd;
      PH_GROW: begin
        wbyte = row_bytes[idx];
        wrs   = 1'b1;
      end
      default: begin
        wbyte = 8'h00;
        wrs   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/chardisp_seq.sv
module chardisp_seq
  import chardisp_pkg::*;
#(
  parameter int unsigned COL_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_glyph,
  input  logic                req_row,
  input  logic [COL_W-1:0]    req_col,
  input  logic [7:0]          req_char,
  input  logic [2:0]          req_code,
  input  logic [BITMAP_W-1:0] req_bitmap,
  input  logic                wr_idle,
  output logic                go,
  output phase_t              phase,
  output logic [2:0]          idx,
  output logic                row_q,
  output logic [COL_W-1:0]    col_q,
  output logic [7:0]          char_q,
  output logic [2:0]          code_q,
  output logic [BITMAP_W-1:0] bitmap_q
);

  localparam logic [2:0] PWR_LAST   = 3'(PWR_LEN - 1);
  localparam logic [2:0] GLYPH_LAST = 3'(GLYPH_BYTES - 1);

  phase_t     ph_q, ph_d;
  logic [2:0] idx_q, idx_d;
  logic       step;
  logic       take;

  assign go        = (ph_q inside {PH_PWR, PH_POS, PH_CHAR, PH_GCMD, PH_GROW, PH_GPOS});
  assign step      = go && wr_idle;
  assign req_ready = (ph_q == PH_READY);
  assign take      = req_ready && req_valid;

  always_comb begin
    ph_d  = ph_q;
    idx_d = idx_q;
    unique case (ph_q)
      PH_PWR: begin
        if (step) begin
          if (idx_q == PWR_LAST) begin
            ph_d  = PH_PWR_DRAIN;
            idx_d = '0;
          end else begin
            idx_d = idx_q + 3'd1;
          end
        end
      end
      PH_PWR_DRAIN: if (wr_idle) ph_d = PH_READY;
      PH_READY: begin
        if (take) begin
          ph_d  = req_glyph ? PH_GCMD : PH_POS;
          idx_d = '0;
        end
      end
      PH_POS:  if (step) ph_d = PH_CHAR;
      PH_CHAR: if (step) ph_d = PH_READY;
      PH_GCMD: if (step) ph_d = PH_GROW;
      PH_GROW: begin
        if (step) begin
          if (idx_q == GLYPH_LAST) begin
            ph_d  = PH_GPOS;
            idx_d = '0;
          end else begin
            idx_d = idx_q + 3'd1;
          end
        end
      end
      PH_GPOS: if (step) ph_d = PH_READY;
      default: ph_d = PH_PWR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_PWR;
      idx_q <= '0;
    end else begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
    end
  end

  // Request fields are captured on acceptance and held for the whole request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q    <= 1'b0;
      col_q    <= '0;
      char_q   <= '0;
      code_q   <= '0;
      bitmap_q <= '0;
    end else if (take) begin
      row_q    <= req_row;
      col_q    <= req_col;
      char_q   <= req_char;
      code_q   <= req_code;
      bitmap_q <= req_bitmap;
    end
  end

  assign phase = ph_q;
  assign idx   = idx_q;

endmodule

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl
  import chardisp_pkg::*;
#(
  parameter int unsigned SETUP_CYC   = 2,
  parameter int unsigned STROBE_CYC  = 3,
  parameter int unsigned GAP_CYC     = 8,
  parameter int unsigned CLR_GAP_CYC = 40,
  parameter int unsigned COL_W       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_glyph,
  input  logic                req_row,
  input  logic [COL_W-1:0]    req_col,
  input  logic [7:0]          req_char,
  input  logic [2:0]          req_code,
  input  logic [BITMAP_W-1:0] req_bitmap,
  output logic                disp_cs_n,
  output logic                disp_wr_n,
  output logic                disp_rs,
  output logic [7:0]          disp_d
);

  logic [1:0]          rst_sync_q;
  logic                rst_core_n;
  logic                wr_idle;
  logic                go;
  phase_t              phase;
  logic [2:0]          idx;
  logic                row_q;
  logic [COL_W-1:0]    col_q;
  logic [7:0]          char_q;
  logic [2:0]          code_q;
  logic [BITMAP_W-1:0] bitmap_q;
  logic [7:0]          wbyte;
  logic                wrs;

  // Reset asserts at once and releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  chardisp_seq #(.COL_W(COL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_glyph  (req_glyph),
    .req_row    (req_row),
    .req_col    (req_col),
    .req_char   (req_char),
    .req_code   (req_code),
    .req_bitmap (req_bitmap),
    .wr_idle    (wr_idle),
    .go         (go),
    .phase      (phase),
    .idx        (idx),
    .row_q      (row_q),
    .col_q      (col_q),
    .char_q     (char_q),
    .code_q     (code_q),
    .bitmap_q   (bitmap_q)
  );

  chardisp_byte_src #(.COL_W(COL_W)) u_src (
    .phase  (phase),
    .idx    (idx),
    .row    (row_q),
    .col    (col_q),
    .chr    (char_q),
    .code   (code_q),
    .bitmap (bitmap_q),
    .wbyte  (wbyte),
    .wrs    (wrs)
  );

  chardisp_bus_wr #(
    .SETUP_CYC   (SETUP_CYC),
    .STROBE_CYC  (STROBE_CYC),
    .GAP_CYC     (GAP_CYC),
    .CLR_GAP_CYC (CLR_GAP_CYC)
  ) u_wr (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .go      (go),
    .go_byte (wbyte),
    .go_rs   (wrs),
    .idle    (wr_idle),
    .cs_n    (disp_cs_n),
    .wr_n    (disp_wr_n),
    .rs      (disp_rs),
    .d       (disp_d)
  );

endmodule

// File: rtl/chardisp_chk.sv
module chardisp_chk #(
  parameter int unsigned GAP_CYC     = 8,
  parameter int unsigned CLR_GAP_CYC = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       wr_n,
  input logic       rs,
  input logic [7:0] d,
  input logic       ready
);

  localparam int unsigned GW = $clog2(CLR_GAP_CYC + 2) + 1;

  logic [GW-1:0] gap_cnt;
  logic          seen_q;
  logic          last_clr_q;
  logic          wr_prev_q;
  logic [2:0]    wr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt    <= '0;
      seen_q     <= 1'b0;
      last_clr_q <= 1'b0;
      wr_prev_q  <= 1'b1;
      wr_done    <= '0;
    end else begin
      if (!cs_n)              gap_cnt <= '0;
      else if (gap_cnt != '1) gap_cnt <= gap_cnt + GW'(1);
      if (!wr_n) begin
        seen_q     <= 1'b1;
        last_clr_q <= !rs && (d == 8'h01);
      end
      wr_prev_q <= wr_n;
      if (wr_n && !wr_prev_q && (wr_done != 3'd4)) wr_done <= wr_done + 3'd1;
    end
  end

  // R3
  ready_after_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done < 3'd4) |-> !ready);

  // R7
  strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);

  // R7
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> ($stable(d) && $stable(rs)));

  // R8
  setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(!cs_n && wr_n));

  // R8
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> cs_n);

  // R9
  recovery_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && seen_q) |-> (gap_cnt >= (last_clr_q ? GW'(CLR_GAP_CYC) : GW'(GAP_CYC))));

endmodule

bind chardisp_ctrl chardisp_chk #(
  .GAP_CYC     (GAP_CYC),
  .CLR_GAP_CYC (CLR_GAP_CYC)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cs_n  (disp_cs_n),
  .wr_n  (disp_wr_n),
  .rs    (disp_rs),
  .d     (disp_d),
  .ready (req_ready)
);

// File: tb/sim_chardisp_ctrl.sv
`timescale 1ns/1ps
module sim_chardisp_ctrl;

  localparam int unsigned SETUP_CYC   = 2;
  localparam int unsigned STROBE_CYC  = 3;
  localparam int unsigned GAP_CYC     = 8;
  localparam int unsigned CLR_GAP_CYC = 40;
  localparam int unsigned COL_W       = 6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic             req_glyph;
  logic             req_row;
  logic [COL_W-1:0] req_col;
  logic [7:0]       req_char;
  logic [2:0]       req_code;
  logic [39:0]      req_bitmap;
  logic             disp_cs_n;
  logic             disp_wr_n;
  logic             disp_rs;
  logic [7:0]       disp_d;

  always #2.5 clk = ~clk;

  chardisp_ctrl #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .GAP_CYC(GAP_CYC),
    .CLR_GAP_CYC(CLR_GAP_CYC), .COL_W(COL_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_glyph(req_glyph), .req_row(req_row), .req_col(req_col), .req_char(req_char),
    .req_code(req_code), .req_bitmap(req_bitmap), .disp_cs_n(disp_cs_n),
    .disp_wr_n(disp_wr_n), .disp_rs(disp_rs), .disp_d(disp_d)
  );

  int    vectors = 0;
  int    errors  = 0;
  bit    finished = 1'b0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // Behavioural bus model: every falling edge compares the bus against the expected-write queue and the timing rules
  logic       prev_cs = 1'b1, prev_wr = 1'b1, prev_rs = 1'b0;
  logic [7:0] prev_d = 8'h00;
  int         setup_run = 0, strobe_run = 0, gap_run = 0, done_writes = 0;
  bit         seen = 1'b0, last_clr = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1'b1; prev_wr = 1'b1;
      setup_run = 0; strobe_run = 0; gap_run = 0; done_writes = 0;
      seen = 1'b0; last_clr = 1'b0;
    end else begin
      logic [8:0] e;
      string t;
      if (!disp_wr_n) chk(!disp_cs_n, "R7 strobe without select", disp_cs_n, 0);
      if (!disp_cs_n && !prev_cs)
        chk({disp_rs, disp_d} == {prev_rs, prev_d}, "R7 bus held during select",
            {disp_rs, disp_d}, {prev_rs, prev_d});
      if (!disp_cs_n && prev_cs) begin
        if (seen) chk(gap_run >= (last_clr ? CLR_GAP_CYC : GAP_CYC), "R9 recovery gap",
                      gap_run, last_clr ? CLR_GAP_CYC : GAP_CYC);
        setup_run = 0;
      end
      if (disp_cs_n) gap_run = prev_cs ? gap_run + 1 : 1;
      if (!disp_cs_n && disp_wr_n) setup_run++;
      if (!disp_wr_n && prev_wr) begin
        chk(setup_run == SETUP_CYC, "R8 setup length", setup_run, SETUP_CYC);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected write", {disp_rs, disp_d}, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({disp_rs, disp_d} == e, t, {disp_rs, disp_d}, e);
        end
        strobe_run = 0;
      end
      if (!disp_wr_n) strobe_run++;
      if (disp_wr_n && !prev_wr) begin
        chk(strobe_run == STROBE_CYC, "R8 strobe length", strobe_run, STROBE_CYC);
        done_writes++;
        last_clr = !disp_rs && (disp_d == 8'h01);
        seen = 1'b1;
      end
      if (done_writes < 4) chk(!req_ready, "R3 ready before power-up done", req_ready, 0);
      prev_cs = disp_cs_n; prev_wr = disp_wr_n; prev_rs = disp_rs; prev_d = disp_d;
    end
  end

  function automatic logic [7:0] pos_byte(input bit row, input int col);
    return 8'h80 | (row ? 8'h40 : 8'h00) | 8'(col);
  endfunction

  task automatic send_char(input bit row, input int col, input logic [7:0] ch);
    req_glyph = 1'b0; req_row = row; req_col = COL_W'(col); req_char = ch; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_q.push_back({1'b0, pos_byte(row, col)}); tag_q.push_back("R4 position command");
    exp_q.push_back({1'b1, ch});                 tag_q.push_back("R4 character data");
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_glyph(input logic [2:0] code, input logic [39:0] bm, input bit row, input int col);
    req_glyph = 1'b1; req_code = code; req_bitmap = bm; req_row = row; req_col = COL_W'(col);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    exp_q.push_back({1'b0, 8'h40 + 8'(code) * 8'd8}); tag_q.push_back("R5 glyph address command");
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back({1'b1, 3'b000, bm[i*5 +: 5]}); tag_q.push_back("R5 glyph row data");
    end
    exp_q.push_back({1'b0, pos_byte(row, col)}); tag_q.push_back("R6 cursor restore");
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    logic [39:0] smile;
    logic [39:0] stripes;
    rst_n = 1'b0; req_valid = 1'b0; req_glyph = 1'b0; req_row = 1'b0; req_col = '0;
    req_char = 8'h00; req_code = 3'd0; req_bitmap = '0;
    exp_q.push_back({1'b0, 8'h38}); tag_q.push_back("R2 power-up command 1");
    exp_q.push_back({1'b0, 8'h0C}); tag_q.push_back("R2 power-up command 2");
    exp_q.push_back({1'b0, 8'h01}); tag_q.push_back("R2 power-up command 3");
    exp_q.push_back({1'b0, 8'h06}); tag_q.push_back("R2 power-up command 4");
    repeat (3) @(negedge clk);
    chk(disp_cs_n === 1'b1 && disp_wr_n === 1'b1 && req_ready === 1'b0, "R1 state in reset",
        {disp_cs_n, disp_wr_n, req_ready}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(disp_cs_n === 1'b1 && disp_wr_n === 1'b1 && req_ready === 1'b0, "R1 state after release",
        {disp_cs_n, disp_wr_n, req_ready}, 3'b110);
    // R3: this request is presented during power-up and held
    send_char(1'b0, 1, 8'h41);
    send_char(1'b1, 2, 8'h42);
    send_char(1'b1, 39, 8'h7A);
    smile = {5'h00, 5'h00, 5'h0E, 5'h11, 5'h00, 5'h00, 5'h0A, 5'h00};
    send_glyph(3'd0, smile, 1'b0, 1);
    stripes = {5'h15, 5'h0A, 5'h1F, 5'h01, 5'h10, 5'h15, 5'h0A, 5'h1F};
    send_glyph(3'd7, stripes, 1'b1, 5);
    send_char(1'b0, 0, 8'h07);
    send_glyph(3'd3, 40'hFF_FFFF_FFFF, 1'b1, 63);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (CLR_GAP_CYC + 10) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected writes seen", exp_q.size(), 0);
    chk(disp_cs_n && disp_wr_n && req_ready, "R9 bus quiet and ready at end",
        {disp_cs_n, disp_wr_n, req_ready}, 3'b111);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++;
      errors++;
      $display("FAIL R2 watchdog: actual %0d pending expected 0 pending", exp_q.size());
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule